// File: doc/BRIEF.md
# Stereo-Duplicating Serial Sample Transmitter

This block sits between a parallel audio sample source and the serial data pin of a codec. On the bit-clock tick where the frame-sync load input is high it captures a sample word. It then drives that word onto a single serial line, most significant bit first. It sends the word twice in a row, so both stereo slots of the frame carry the same mono sample.

Every change of the serial line is paced by a one-cycle enable tick. The tick marks the falling edge of the bit clock, so the codec always sees data that is stable across its rising-edge sampling point. Once both copies have been sent, the line rests at 0 until the next load. Frame syncs normally arrive once every 64 bit-clock periods. The bit-clock and frame-sync generators and the sample producer live outside this block.

Top module: `dactx_stereo_serializer`

## Requirements
- R1: While reset is asserted and after its release, the serial output is 0 and no bits are pending, so ticks without a load keep the output at 0.
- R2: A load input that is high only on cycles where the tick is low captures nothing: the output is unchanged on those cycles and later ticks behave as if no load had occurred.
- R3: On a system-clock edge where both tick and load are high, the word is captured and the serial output, one clock later, equals bit 15 (the MSB) of that word.
- R4: On each following tick the output advances by one bit, from MSB toward LSB, so tick k after the capture tick (k = 1..15) shows bit 15-k.
- R5: The tick after bit 0 of the first copy shows bit 15 of the same word again, with no gap, and the second copy runs down to bit 0 over ticks 16..31 after capture.
- R6: The serial output changes only at clock edges where the tick is high.
- R7: From the 32nd tick after the capture tick onward, the output is held at 0 until the next load.
- R8: A load tick that arrives while a word is still being sent abandons that word and starts the new word from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle enable marking each bit-clock falling edge |
| frame_load_i | input | 1 | Frame-sync load request, acted on only with a tick |
| sample_i | input | 16 | Parallel sample word |
| sdata_o | output | 1 | Serial data toward the codec |

## Verification
The bench targets the seam between the two copies. A design that failed to wrap the word would send zeros or shifted garbage in the second slot, and one with an off-by-one counter would drop or repeat a bit there. It also drives loads that fall between ticks, which a design gating capture only on load would wrongly latch. It drives a new load partway through a word, which a design that ignores load while busy would let finish. It checks the output on every non-tick cycle, which catches any shift that runs on the system clock instead of the tick. A reset mid-word must silence the line, not resume it. Words such as all-ones, single-end-bit and alternating patterns make wrong ordering or an early stop visible as a bit mismatch.

// File: rtl/dactx_pkg.sv
package dactx_pkg;

    // Where the next serial bit comes from on a given cycle.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_FRESH = 2'd1,
        SRC_SHIFT = 2'd2,
        SRC_ZERO  = 2'd3
    } tx_src_e;

    typedef struct packed {
        logic sdata;
    } tx_out_t;

endpackage

// File: rtl/dactx_bit_counter.sv
module dactx_bit_counter #(
    parameter int WORD_W = 16,
    parameter int COPIES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    output logic busy_o
);
    localparam int TOTAL = WORD_W * COPIES;
    localparam int CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] remaining;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d.remaining = LAST_C;
        end else if (step_i && (cnt_q.remaining != '0)) begin
            cnt_d.remaining = cnt_q.remaining - ONE_C;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q.remaining != '0);

endmodule

// File: rtl/dactx_word_rotator.sv
module dactx_word_rotator #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              advance_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              head_o
);
    typedef struct packed {
        logic [WORD_W-1:0] bits;
    } rot_state_t;

    rot_state_t rot_d, rot_q;

    // Rotate left: after WORD_W steps the word is back in place,
    // which supplies every further copy without a second register.
    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction

    always_comb begin
        rot_d = rot_q;
        if (capture_i) begin
            rot_d.bits = rotl(word_i);
        end else if (advance_i) begin
            rot_d.bits = rotl(rot_q.bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_q <= '0;
        end else begin
            rot_q <= rot_d;
        end
    end

    assign head_o = rot_q.bits[WORD_W-1];

endmodule

// File: rtl/dactx_stereo_serializer.sv
module dactx_stereo_serializer #(
    parameter int WORD_W = 16,
    parameter int COPIES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick_i,
    input  logic              frame_load_i,
    input  logic [WORD_W-1:0] sample_i,
    output logic              sdata_o
);
    import dactx_pkg::*;

    localparam int MSB = WORD_W - 1;

    logic    capture;
    logic    advance;
    logic    busy;
    logic    head_bit;
    tx_src_e src;
    tx_out_t out_d, out_q;

    assign capture = bit_tick_i & frame_load_i;
    assign advance = bit_tick_i & ~frame_load_i & busy;

    dactx_bit_counter #(
        .WORD_W (WORD_W),
        .COPIES (COPIES)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (capture),
        .step_i  (advance),
        .busy_o  (busy)
    );

    dactx_word_rotator #(
        .WORD_W (WORD_W)
    ) i_rotator (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .advance_i (advance),
        .word_i    (sample_i),
        .head_o    (head_bit)
    );

    always_comb begin
        src = SRC_HOLD;
        if (bit_tick_i) begin
            if (frame_load_i) begin
                src = SRC_FRESH;
            end else if (busy) begin
                src = SRC_SHIFT;
            end else begin
                src = SRC_ZERO;
            end
        end

        out_d = out_q;
        case (src)
            SRC_FRESH: out_d.sdata = sample_i[MSB];
            SRC_SHIFT: out_d.sdata = head_bit;
            SRC_ZERO:  out_d.sdata = 1'b0;
            default:   out_d       = out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sdata_o = out_q.sdata;

endmodule

// File: rtl/dactx_checker.sv
module dactx_checker #(
    parameter int WORD_W = 16,
    parameter int COPIES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick_i,
    input logic              frame_load_i,
    input logic [WORD_W-1:0] sample_i,
    input logic              sdata_o
);
    localparam int TOTAL = WORD_W * COPIES;
    localparam int CHK_W = $clog2(TOTAL + 2);
    localparam logic [CHK_W-1:0] TOTAL_C = CHK_W'(TOTAL);
    localparam logic [CHK_W-1:0] ONE_C   = CHK_W'(1);
    localparam logic [CHK_W-1:0] SEAM_C  = CHK_W'(WORD_W + 1);

    // Count of bits shown for the current word (1 = MSB of first copy).
    logic [CHK_W-1:0]  shown_q;
    logic [WORD_W-1:0] held_q;
    logic              exp_bit;
    int unsigned       pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shown_q <= '0;
            held_q  <= '0;
        end else if (bit_tick_i) begin
            if (frame_load_i) begin
                shown_q <= ONE_C;
                held_q  <= sample_i;
            end else if ((shown_q != '0) && (shown_q <= TOTAL_C)) begin
                shown_q <= shown_q + ONE_C;
            end
        end
    end

    always_comb begin
        pos     = (32'(shown_q) - 1) % WORD_W;
        exp_bit = held_q[WORD_W - 1 - pos];
    end

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((shown_q == '0) || (shown_q > TOTAL_C)) |-> (sdata_o == 1'b0));

    assert_bit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((shown_q != '0) && (shown_q <= TOTAL_C)) |-> (sdata_o == exp_bit));

    assert_second_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shown_q == SEAM_C) |-> (sdata_o == held_q[WORD_W-1]));

    assert_capture_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick_i && frame_load_i) |=> (sdata_o == $past(sample_i[WORD_W-1])));

    assert_tick_paced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick_i |=> $stable(sdata_o));

    assert_stray_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_load_i && !bit_tick_i) |=> $stable(sdata_o));

endmodule

bind dactx_stereo_serializer dactx_checker #(
    .WORD_W (WORD_W),
    .COPIES (COPIES)
) i_dactx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick_i   (bit_tick_i),
    .frame_load_i (frame_load_i),
    .sample_i     (sample_i),
    .sdata_o      (sdata_o)
);

// File: tb/test_dactx_stereo_serializer.sv
module test_dactx_stereo_serializer;

    localparam int TICK_GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick_i = 1'b0;
    logic        frame_load_i = 1'b0;
    logic [15:0] sample_i = '0;
    logic        sdata_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit    val;
        string tag;
    } exp_t;

    exp_t        exp_q[$];
    bit          exp_last = 1'b0;
    logic [15:0] cur = '0;
    int          sent = 0;
    bit          stray_flag = 1'b0;
    bit          restart_flag = 1'b0;

    always #5 clk = ~clk;

    dactx_stereo_serializer i_dactx_stereo_serializer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick_i   (bit_tick_i),
        .frame_load_i (frame_load_i),
        .sample_i     (sample_i),
        .sdata_o      (sdata_o)
    );

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sdata_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: predicts the bit for this tick, queues it, then issues the tick.
    task automatic tick_once(input bit ld, input logic [15:0] w);
        exp_t it;
        if (ld) begin
            it.tag = restart_flag ? "R8" : "R3";
            restart_flag = 1'b0;
            cur = w;
            sent = 1;
            it.val = w[15];
        end else if (sent >= 1 && sent < 32) begin
            it.val = cur[15 - (sent % 16)];
            it.tag = (sent < 16) ? "R4" : "R5";
            sent++;
        end else begin
            it.val = 1'b0;
            it.tag = (sent == 0) ? "R1" : "R7";
        end
        if (stray_flag) begin
            it.tag = "R2";
            stray_flag = 1'b0;
        end
        exp_q.push_back(it);
        bit_tick_i   = 1'b1;
        frame_load_i = ld;
        sample_i     = w;
        @(negedge clk);
        bit_tick_i   = 1'b0;
        frame_load_i = 1'b0;
        repeat (TICK_GAP - 1) @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) tick_once(1'b0, 16'h0000);
    endtask

    task automatic frame(input logic [15:0] w);
        tick_once(1'b1, w);
        idle_ticks(63);
    endtask

    task automatic stray_load(input logic [15:0] w);
        frame_load_i = 1'b1;
        sample_i     = w;
        repeat (3) @(negedge clk);
        frame_load_i = 1'b0;
        stray_flag   = 1'b1;
    endtask

    task automatic do_reset();
        #2;
        rst_n    = 1'b0;
        exp_last = 1'b0;
        sent     = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: compares on every cycle, popping an expected bit after each tick.
    initial begin
        bit had;
        exp_t it;
        forever begin
            @(posedge clk);
            had = bit_tick_i;
            @(negedge clk);
            if (had) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R6: sdata_o=%0b expected no tick", sdata_o);
                end else begin
                    it = exp_q.pop_front();
                    check(it.tag, sdata_o, it.val);
                    exp_last = it.val;
                end
            end else begin
                check(rst_n ? "R6" : "R1", sdata_o, exp_last);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R6: watchdog expired, done=%0b expected 1", done);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_ticks(3);                     // R1: idle after reset

        frame(16'hA5C3);                   // R3 R4 R5 R7
        frame(16'h8001);
        frame(16'hFFFF);
        frame(16'h7FFE);
        frame(16'h0000);

        stray_load(16'hFFFF);              // R2: load between ticks while idle
        idle_ticks(2);

        tick_once(1'b1, 16'h1234);         // R2: stray load mid-word
        idle_ticks(5);
        stray_load(16'hFFFF);
        idle_ticks(58);

        tick_once(1'b1, 16'hC0DE);         // R8: restart mid-word
        idle_ticks(10);
        restart_flag = 1'b1;
        frame(16'h5A5A);

        tick_once(1'b1, 16'hFFFF);         // R1: reset mid-word
        idle_ticks(5);
        do_reset();
        idle_ticks(3);
        frame(16'h9669);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule